// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This block is a 32-bit combinational arithmetic datapath with one registered sticky saturation flag. It computes signed and unsigned saturating sums and differences, a doubling operation with signed saturation, a plain wrapping add that still reports signed overflow, and clamping of a value to a chosen bit position. The clamp-to-position operations can act on the whole word, or on two independent 16-bit halves packed back into one word.

The result follows the inputs in the same cycle. Any clamp or overflow event sets the sticky flag at the next rising clock edge. The flag is cleared only by a one-cycle clear strobe or by reset, so software can run a long chain of operations and check once whether any step lost precision. The flag has two named states: CLEAN (flag low) and STICKY (flag high). It moves CLEAN to STICKY on an event ("set"), STICKY to CLEAN on a clear strobe with no event in the same cycle ("clear"), and otherwise stays put ("hold"). Reset forces CLEAN.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (wrapping add) returns the low 32 bits of op_a+op_b. It raises an event when both operands have the same sign and the sum's sign differs from op_a's.
- R2: Opcodes 1 (signed saturating add) and 2 (signed saturating subtract) return the wrapped result when there is no overflow. On overflow they return 0x7FFFFFFF if op_a is non-negative and 0x80000000 if it is negative, and raise an event. Subtract overflows when the operands differ in sign and the difference's sign differs from op_a's.
- R3: Opcode 3 (doubling) acts on op_a as a signed value. It returns 0x7FFFFFFF with an event for values at or above 0x40000000, and 0x80000000 with an event for values at or below 0xC0000000 (that is, -2^30). Any other value is returned shifted left by one, with no event.
- R4: Opcode 4 (unsigned saturating add) returns 0xFFFFFFFF with an event when the add carries out. Opcode 5 (unsigned saturating subtract) returns 0 with an event when op_b is greater than op_a. Otherwise both return the plain result.
- R5: Opcode 6 (signed clamp to position n = sat_pos) arithmetically shifts op_a right by n. If the shifted value is positive, the result is 2^n-1. If it is below -1, the result is the bitwise complement of 2^n-1. In both cases an event is raised. Otherwise op_a passes through unchanged.
- R6: Opcode 7 (unsigned clamp to position n) returns 0 for a negative op_a and 2^n-1 for op_a above 2^n-1, raising an event in both cases. Otherwise op_a passes through unchanged.
- R7: Opcodes 8 (signed) and 9 (unsigned) apply the R5 and R6 rules separately to the sign-extended halves op_a[15:0] and op_a[31:16]. The low-half result goes to result[15:0] and the high-half result to result[31:16]. An event from either half raises an event.
- R8: Opcodes 10 to 15 return 0, raise no event, and leave the flag unchanged.
- R9: An event sets sat_flag at the next rising edge. An event in the same cycle as flag_clr still leaves the flag set.
- R10: sat_flag is 0 after reset. It falls at the edge after a flag_clr pulse that has no event in the same cycle. No arithmetic operation clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 4 | Operation select (see requirements) |
| sat_pos | input | 5 | Clamp bit position n |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A clamp event and a flag_clr strobe can occur in the same cycle. The bench provokes this directly with an overflowing signed add issued while the clear strobe is high. It also hits the combination at random, because random steps assert the strobe about one time in eight. In that case the flag must read set one cycle later, while a clear strobe on its own must read clean one cycle later. Both outcomes are judged against a reference flag the bench keeps.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADDW  = 4'd0,
        OP_QADD  = 4'd1,
        OP_QSUB  = 4'd2,
        OP_QDBL  = 4'd3,
        OP_UQADD = 4'd4,
        OP_UQSUB = 4'd5,
        OP_SSAT  = 4'd6,
        OP_USAT  = 4'd7,
        OP_SSAT2 = 4'd8,
        OP_USAT2 = 4'd9
    } sat_op_e;

    typedef enum logic {
        FLAG_CLEAN  = 1'b0,
        FLAG_STICKY = 1'b1
    } flag_state_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  sat_op_e      op,
    output logic [W-1:0] res,
    output logic         hit
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] QPOS = {2'b01, {(W-2){1'b0}}};
    localparam logic [W-1:0] QNEG = {2'b11, {(W-2){1'b0}}};

    logic [W:0]   sum;
    logic [W:0]   dif;
    logic         add_ovf;
    logic         sub_ovf;
    logic [W-1:0] s_clamp;

    assign sum     = {1'b0, a} + {1'b0, b};
    assign dif     = {1'b0, a} - {1'b0, b};
    assign add_ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    assign sub_ovf = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
    assign s_clamp = a[W-1] ? SMIN : SMAX;

    always_comb begin
        res = sum[W-1:0];
        hit = 1'b0;
        unique case (op)
            OP_ADDW: begin
                res = sum[W-1:0];
                hit = add_ovf;
            end
            OP_QADD: begin
                res = add_ovf ? s_clamp : sum[W-1:0];
                hit = add_ovf;
            end
            OP_QSUB: begin
                res = sub_ovf ? s_clamp : dif[W-1:0];
                hit = sub_ovf;
            end
            OP_QDBL: begin
                if ($signed(a) >= $signed(QPOS)) begin
                    res = SMAX;
                    hit = 1'b1;
                end else if ($signed(a) <= $signed(QNEG)) begin
                    res = SMIN;
                    hit = 1'b1;
                end else begin
                    res = {a[W-2:0], 1'b0};
                end
            end
            OP_UQADD: begin
                res = sum[W] ? {W{1'b1}} : sum[W-1:0];
                hit = sum[W];
            end
            OP_UQSUB: begin
                res = dif[W] ? '0 : dif[W-1:0];
                hit = dif[W];
            end
            default: begin
                res = '0;
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W  = 32,
    parameter int PW = 5
) (
    input  logic [W-1:0]  val,
    input  logic [PW-1:0] pos,
    input  logic          is_signed,
    output logic [W-1:0]  res,
    output logic          hit
);
    logic [W-1:0]        mask;
    logic signed [W-1:0] shr;

    assign mask = ({{(W-1){1'b0}}, 1'b1} << pos) - {{(W-1){1'b0}}, 1'b1};
    assign shr  = $signed(val) >>> pos;

    always_comb begin
        res = val;
        hit = 1'b0;
        if (is_signed) begin
            if (!shr[W-1] && (shr != '0)) begin
                res = mask;
                hit = 1'b1;
            end else if (shr[W-1] && (shr != '1)) begin
                res = ~mask;
                hit = 1'b1;
            end
        end else begin
            if (val[W-1]) begin
                res = '0;
                hit = 1'b1;
            end else if (val > mask) begin
                res = mask;
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky
    import sat_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAN:  if (set_evt) state_d = FLAG_STICKY;
            FLAG_STICKY: if (clr && !set_evt) state_d = FLAG_CLEAN;
            default:     state_d = FLAG_CLEAN;
        endcase
    end

    assign flag = (state_q == FLAG_STICKY);

    // R9: an event always leaves the flag set, even with a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R10: only the clear strobe drops a set flag
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set_evt |=> !flag);
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DATA_W-1:0]         op_a,
    input  logic [DATA_W-1:0]         op_b,
    input  logic [3:0]                opcode,
    input  logic [$clog2(DATA_W)-1:0] sat_pos,
    input  logic                      flag_clr,
    output logic [DATA_W-1:0]         result,
    output logic                      sat_flag
);
    localparam int POS_W = $clog2(DATA_W);
    localparam int LANES = 2;
    localparam int LW    = DATA_W / LANES;
    localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

    sat_op_e           op_e;
    logic [DATA_W-1:0] as_res;
    logic              as_hit;
    logic [DATA_W-1:0] wd_res;
    logic              wd_hit;
    logic [DATA_W-1:0] pk_res;
    logic [LANES-1:0]  ln_hit;
    logic              clamp_evt;

    assign op_e = sat_op_e'(opcode);

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a   (op_a),
        .b   (op_b),
        .op  (op_e),
        .res (as_res),
        .hit (as_hit)
    );

    sat_clamp #(.W(DATA_W), .PW(POS_W)) u_word (
        .val       (op_a),
        .pos       (sat_pos),
        .is_signed (op_e == OP_SSAT),
        .res       (wd_res),
        .hit       (wd_hit)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.W(LW), .PW(POS_W)) u_half (
            .val       (op_a[g*LW +: LW]),
            .pos       (sat_pos),
            .is_signed (op_e == OP_SSAT2),
            .res       (pk_res[g*LW +: LW]),
            .hit       (ln_hit[g])
        );
    end

    always_comb begin
        result    = '0;
        clamp_evt = 1'b0;
        unique case (op_e)
            OP_ADDW, OP_QADD, OP_QSUB, OP_QDBL, OP_UQADD, OP_UQSUB: begin
                result    = as_res;
                clamp_evt = as_hit;
            end
            OP_SSAT, OP_USAT: begin
                result    = wd_res;
                clamp_evt = wd_hit;
            end
            OP_SSAT2, OP_USAT2: begin
                result    = pk_res;
                clamp_evt = |ln_hit;
            end
            default: begin
                result    = '0;
                clamp_evt = 1'b0;
            end
        endcase
    end

    sat_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (clamp_evt),
        .clr     (flag_clr),
        .flag    (sat_flag)
    );

    // R2: a signed overflow clamps toward the sign of op_a
    p_signed_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_e == OP_QADD) || (op_e == OP_QSUB)) && clamp_evt
        |-> result == (op_a[DATA_W-1] ? SMIN : SMAX));
    // R4: unsigned clamps land on the range ends
    p_uadd_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_UQADD) && clamp_evt |-> result == {DATA_W{1'b1}});
    p_usub_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_UQSUB) && clamp_evt |-> result == '0);
    // R8: spare opcodes are silent
    p_spare_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode > 4'd9) |-> (result == '0) && !clamp_evt);
endmodule

// File: tb/sat_alu_tb.sv
`timescale 1ns/1ps
module sat_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic [4:0]  sat_pos = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] result;
    logic        sat_flag;

    int errors = 0;
    int checks = 0;
    logic model_flag = 1'b0;

    always #2.5 clk = ~clk;

    sat_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .sat_pos(sat_pos), .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] ref_ss(logic [31:0] x, logic [4:0] n);
        int v = $signed(x);
        int t = v >>> n;
        logic [31:0] m = (32'h1 << n) - 32'h1;
        if (t > 0)       return {1'b1, m};
        else if (t < -1) return {1'b1, ~m};
        return {1'b0, x};
    endfunction

    function automatic logic [32:0] ref_us(logic [31:0] x, logic [4:0] n);
        logic [31:0] m = (32'h1 << n) - 32'h1;
        if (x[31])      return {1'b1, 32'h0};
        else if (x > m) return {1'b1, m};
        return {1'b0, x};
    endfunction

    function automatic logic [32:0] ref_op(logic [3:0] op, logic [31:0] a,
                                           logic [31:0] b, logic [4:0] n);
        logic [32:0] s = {1'b0, a} + {1'b0, b};
        logic [32:0] d = {1'b0, a} - {1'b0, b};
        logic [32:0] l0, l1;
        logic [31:0] r = '0;
        logic h = 1'b0;
        int sa = $signed(a);
        case (op)
            4'd0: begin r = s[31:0]; h = (a[31] == b[31]) && (s[31] != a[31]); end
            4'd1: begin
                h = (a[31] == b[31]) && (s[31] != a[31]);
                r = h ? (a[31] ? 32'h80000000 : 32'h7FFFFFFF) : s[31:0];
            end
            4'd2: begin
                h = (a[31] != b[31]) && (d[31] != a[31]);
                r = h ? (a[31] ? 32'h80000000 : 32'h7FFFFFFF) : d[31:0];
            end
            4'd3: begin
                if (sa >= 1073741824)       begin r = 32'h7FFFFFFF; h = 1'b1; end
                else if (sa <= -1073741824) begin r = 32'h80000000; h = 1'b1; end
                else r = a << 1;
            end
            4'd4: begin h = s[32]; r = h ? 32'hFFFFFFFF : s[31:0]; end
            4'd5: begin h = (a < b); r = h ? 32'h0 : d[31:0]; end
            4'd6: {h, r} = ref_ss(a, n);
            4'd7: {h, r} = ref_us(a, n);
            4'd8: begin
                l0 = ref_ss({{16{a[15]}}, a[15:0]}, n);
                l1 = ref_ss({{16{a[31]}}, a[31:16]}, n);
                r = {l1[15:0], l0[15:0]}; h = l0[32] | l1[32];
            end
            4'd9: begin
                l0 = ref_us({{16{a[15]}}, a[15:0]}, n);
                l1 = ref_us({{16{a[31]}}, a[31:16]}, n);
                r = {l1[15:0], l0[15:0]}; h = l0[32] | l1[32];
            end
            default: begin r = '0; h = 1'b0; end
        endcase
        return {h, r};
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                        logic [4:0] n, logic clr);
        logic [32:0] exp;
        string ftag;
        opcode = op; op_a = a; op_b = b; sat_pos = n; flag_clr = clr;
        #1;
        exp = ref_op(op, a, b, n);
        check(req, result, exp[31:0]);
        model_flag = exp[32] ? 1'b1 : (clr ? 1'b0 : model_flag);
        ftag = exp[32] ? "R9" : (clr ? "R10" : req);
        @(negedge clk);
        check(ftag, {31'b0, sat_flag}, {31'b0, model_flag});
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] ra, rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", {31'b0, sat_flag}, 32'h0);
        check("R1", result, 32'h0);
        @(negedge clk);

        step("R1",  4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
        step("R10", 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
        step("R1",  4'd0, 32'h12345678, 32'h11111111, 5'd0, 1'b0);
        step("R2",  4'd1, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
        step("R2",  4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b0);
        step("R2",  4'd2, 32'h80000000, 32'h1, 5'd0, 1'b0);
        step("R2",  4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b1);
        step("R10", 4'd2, 32'h5, 32'h3, 5'd0, 1'b1);
        step("R3",  4'd3, 32'h40000000, 32'h0, 5'd0, 1'b0);
        step("R3",  4'd3, 32'hC0000000, 32'h0, 5'd0, 1'b0);
        step("R3",  4'd3, 32'hC0000001, 32'h0, 5'd0, 1'b1);
        step("R3",  4'd3, 32'h3FFFFFFF, 32'h0, 5'd0, 1'b0);
        step("R4",  4'd4, 32'hFFFFFFFF, 32'h2, 5'd0, 1'b0);
        step("R4",  4'd5, 32'h1, 32'h2, 5'd0, 1'b0);
        step("R4",  4'd5, 32'h9, 32'h2, 5'd0, 1'b1);
        step("R5",  4'd6, 32'h00000080, 32'h0, 5'd7, 1'b0);
        step("R5",  4'd6, 32'hFFFFFF80, 32'h0, 5'd7, 1'b1);
        step("R5",  4'd6, 32'hFFFFFF7F, 32'h0, 5'd7, 1'b0);
        step("R6",  4'd7, 32'h00000100, 32'h0, 5'd8, 1'b1);
        step("R6",  4'd7, 32'hFFFFFFFF, 32'h0, 5'd8, 1'b1);
        step("R6",  4'd7, 32'h000000FF, 32'h0, 5'd8, 1'b1);
        step("R7",  4'd8, 32'h80000100, 32'h0, 5'd7, 1'b1);
        step("R7",  4'd9, 32'hFFFF0010, 32'h0, 5'd4, 1'b1);
        step("R7",  4'd8, 32'h7FFF8000, 32'h0, 5'd16, 1'b1);
        step("R8",  4'd12, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd3, 1'b0);
        step("R1",  4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b0);
        step("R8",  4'd15, 32'hFFFFFFFF, 32'h1, 5'd0, 1'b0);
        // clamp and clear in the same cycle: the flag stays set
        step("R9",  4'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b1);
        // reset drops a set flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_flag = 1'b0;
        check("R10", {31'b0, sat_flag}, 32'h0);

        void'($urandom(32'd2024));
        for (int i = 0; i < 600; i++) begin
            logic [3:0] rop = 4'($urandom % 11);
            case ($urandom % 4)
                0: ra = 32'h7FFFFFF0 + ($urandom % 32);
                1: ra = 32'h80000000 + ($urandom % 32) - 16;
                default: ra = $urandom;
            endcase
            rb = ($urandom % 3 == 0) ? ($urandom % 64) : $urandom;
            if (rop == 4'd10) rop = 4'd8 + 4'($urandom % 8);
            step(rop == 4'd0 ? "R1" : rop <= 4'd2 ? "R2" : rop == 4'd3 ? "R3" :
                 rop <= 4'd5 ? "R4" : rop == 4'd6 ? "R5" : rop == 4'd7 ? "R6" :
                 rop <= 4'd9 ? "R7" : "R8",
                 rop, ra, rb, 5'($urandom % 32), ($urandom % 8) == 0);
        end
        finish_run();
    end
endmodule